// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Entry Locking

This block is a fully associative address translation cache for 32-bit virtual addresses. Software fills it one entry at a time. It writes a tag word and a data word into two staging registers. It places the replacement pointer with a lock register, then strobes a load. Every lookup compares the virtual page against all entries at once. The block returns the translated address together with the page attributes, a hit flag, a miss flag and a multi-match flag, all one clock after the request.

The lowest entries can be fenced off with a lock base. The replacement pointer never enters that region, and it wraps back to the base instead of to zero. Each entry also carries a protect flag, and a flush leaves protected entries valid. Miss and multi-match events set sticky status bits. Each status bit is cleared by writing 1 to it and has its own enable. A single interrupt line reports them. While translation is disabled, addresses pass through unchanged. A soft reset empties the whole block, and a done flag shows when it has finished.

Top module: `tlb_xlate`

## Requirements
- R1: After the reset input, every register reads 0, translation is off, `irq` is 0 and `rst_done` is 1.
- R2: Register map by word address: 0 control (bit 1 enable, bit 0 soft reset), 1 staged tag, 2 staged data, 3 lock, 4 load (bit 0), 5 flush (bit 0), 6 interrupt status, 7 interrupt enable. Address 4 and address 5 read as 0. Writing 1 to bit 0 of address 4 copies the staged words into the entry named by the replacement pointer.
- R3: Staged tag layout: virtual tag in bits 31:12, protect in bit 3, valid in bit 2, page-size code in bits 1:0. Staged data layout: physical page in bits 31:12, endianness in bit 9, element size in bits 8:7, mixed in bit 6. The page-size codes are 2'b10 for 4 KB, 2'b01 for 64 KB, 2'b00 for 1 MB and 2'b11 for 16 MB. The code sets how many low tag bits above bit 11 the compare ignores and the output takes from the virtual address: 0, 4, 8 or 12.
- R4: After each load, the replacement pointer advances by one. From the last entry (31), it wraps to the lock base.
- R5: Lock register layout: pointer in bits 8:4, lock base in bits 14:10. A written pointer below the written base is clamped up to the base. The pointer never drops below the base.
- R6: Writing 1 to bit 0 of address 5 clears valid on every entry whose protect flag is 0. Protected entries keep translating.
- R7: An enabled lookup that matches no valid entry gives `lk_miss` = 1 and `lk_hit` = 0, and sets status bit 0.
- R8: An enabled lookup that matches more than one entry gives `lk_multi` = 1 and `lk_hit` = 1, and sets status bit 4. The address and attributes come from the lowest-numbered matching entry.
- R9: While the enable bit is 0, `lk_paddr` equals the requested address, and hit, miss and multi are all 0.
- R10: Writing 1 to control bit 0 drops `rst_done` for exactly one cycle. It then returns every entry and register to the R1 state.
- R11: Writing 1 to a status bit clears it. If an event occurs in the same cycle, the event wins. Interrupt-enable bits 0 and 4 are the only stored enable bits, and `irq` is the OR of status bits whose enable is set.
- R12: Lookup results appear one cycle after `lk_valid`, with `lk_ovalid` = 1. `lk_attr` is {endianness, element size, mixed} of the hit entry, and 0 otherwise. Hit, miss and multi are 0 while `lk_ovalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (also selects read data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ovalid | output | 1 | Lookup result valid |
| lk_paddr | output | 32 | Translated or passed-through address |
| lk_hit | output | 1 | At least one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | More than one entry matched |
| lk_attr | output | 4 | {endianness, element size[1:0], mixed} of the hit |
| irq | output | 1 | OR of enabled status bits |
| rst_done | output | 1 | Low while a soft reset is in progress |

## Verification
Each of the four page sizes is tried with an address whose offset bits differ from the physical page. This separates a correct merge from a plain copy and from a wrong mask width. A duplicate tag loaded at a higher index is used to show that the multi flag and status bit are set and that the lowest index supplies the address. A miss shows the miss flag and its status bit. A run of loads long enough to wrap the pointer, together with a lock write below the base, tells clamping and base-relative wrap apart from a wrap to zero. A flush over a mix of protected and unprotected entries, a lookup with translation off, and a soft reset followed by a register sweep cover the remaining controls.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = VA_W - PG_SHIFT;

    // Field positions that software relies on.
    localparam int LOCK_VICT_LSB = 4;
    localparam int LOCK_BASE_LSB = 10;
    localparam int ST_MISS_BIT   = 0;
    localparam int ST_MULTI_BIT  = 4;

    typedef enum logic [1:0] {
        PS_1M  = 2'b00,
        PS_64K = 2'b01,
        PS_4K  = 2'b10,
        PS_16M = 2'b11
    } pgsz_e;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_TAG   = 3'd1,
        RA_DATA  = 3'd2,
        RA_LOCK  = 3'd3,
        RA_LOAD  = 3'd4,
        RA_FLUSH = 3'd5,
        RA_IRQST = 3'd6,
        RA_IRQEN = 3'd7
    } regaddr_e;

    typedef struct packed {
        logic [VPN_W-1:0] vtag;
        logic             prot;
        logic             vld;
        pgsz_e            psz;
    } tag_t;

    typedef struct packed {
        logic       endian;
        logic [1:0] esize;
        logic       mixed;
    } attr_t;

    typedef struct packed {
        logic [VPN_W-1:0] ppn;
        attr_t            attr;
    } data_t;

    // Bits of the page number that take part in the compare.
    function automatic logic [VPN_W-1:0] cmp_mask(pgsz_e p);
        logic [VPN_W-1:0] ones;
        ones = '1;
        case (p)
            PS_4K:   return ones;
            PS_64K:  return ones << 4;
            PS_1M:   return ones << 8;
            default: return ones << 12;
        endcase
    endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 32,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_idx,
    input  tag_t               ld_tag,
    input  data_t              ld_data,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [NUM_ENT-1:0] match_vec,
    output logic [VPN_W-1:0]   sel_vpn,
    output attr_t              sel_attr
);
    logic  [NUM_ENT-1:0][VPN_W-1:0] pa_vec;
    attr_t [NUM_ENT-1:0]            at_vec;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        tag_t             t_q;
        logic [VPN_W-1:0] p_q;
        attr_t            a_q;
        logic [VPN_W-1:0] msk;

        always_ff @(posedge clk) begin
            if (clr) begin
                t_q <= '0;
                p_q <= '0;
                a_q <= '0;
            end else if (ld_en && ld_idx == IDX_W'(g)) begin
                t_q <= ld_tag;
                p_q <= ld_data.ppn;
                a_q <= ld_data.attr;
            end else if (flush) begin
                t_q.vld <= t_q.vld & t_q.prot;
            end
        end

        assign msk          = cmp_mask(t_q.psz);
        assign match_vec[g] = t_q.vld && (((lk_vpn ^ t_q.vtag) & msk) == '0);
        assign pa_vec[g]    = (p_q & msk) | (lk_vpn & ~msk);
        assign at_vec[g]    = a_q;
    end

    // Lowest index wins when several entries match.
    always_comb begin
        sel_vpn  = '0;
        sel_attr = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel_vpn  = pa_vec[i];
                sel_attr = at_vec[i];
            end
        end
    end
endmodule

// File: rtl/tlb_victim_ctrl.sv
module tlb_victim_ctrl #(
    parameter int NUM_ENT = 32,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             lock_we,
    input  logic [IDX_W-1:0] wr_victim,
    input  logic [IDX_W-1:0] wr_base,
    input  logic             adv,
    output logic [IDX_W-1:0] victim,
    output logic [IDX_W-1:0] base
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

    always_ff @(posedge clk) begin
        if (clr) begin
            victim <= '0;
            base   <= '0;
        end else if (lock_we) begin
            base   <= wr_base;
            victim <= (wr_victim < wr_base) ? wr_base : wr_victim;
        end else if (adv) begin
            victim <= (victim == LAST) ? base : victim + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENT = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    output logic        lk_ovalid,
    output logic [31:0] lk_paddr,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic        lk_multi,
    output logic [3:0]  lk_attr,
    output logic        irq,
    output logic        rst_done
);
    localparam int IDX_W = $clog2(NUM_ENT);

    logic        en_q, srst_q, clr;
    logic [31:0] stg_tag, stg_data;
    logic [1:0]  irq_st, irq_en;   // [0] miss, [1] multi
    logic [IDX_W-1:0] vic_idx, lock_base;

    regaddr_e ra;
    logic     wr_ctrl, wr_lock, do_load, do_flush, wr_st, wr_ie;
    assign ra       = regaddr_e'(reg_addr);
    assign clr      = rst | srst_q;
    assign wr_ctrl  = reg_wr && ra == RA_CTRL;
    assign wr_lock  = reg_wr && ra == RA_LOCK;
    assign do_load  = reg_wr && ra == RA_LOAD && reg_wdata[0];
    assign do_flush = reg_wr && ra == RA_FLUSH && reg_wdata[0];
    assign wr_st    = reg_wr && ra == RA_IRQST;
    assign wr_ie    = reg_wr && ra == RA_IRQEN;

    tag_t  ld_tag;
    data_t ld_data;
    assign ld_tag  = '{vtag: stg_tag[31:12], prot: stg_tag[3], vld: stg_tag[2],
                       psz: pgsz_e'(stg_tag[1:0])};
    assign ld_data = '{ppn: stg_data[31:12],
                       attr: '{endian: stg_data[9], esize: stg_data[8:7], mixed: stg_data[6]}};

    logic [NUM_ENT-1:0] match_vec;
    logic [VPN_W-1:0]   sel_vpn;
    attr_t              sel_attr;

    tlb_entry_array #(.NUM_ENT(NUM_ENT)) u_array (
        .clk(clk), .clr(clr), .ld_en(do_load), .ld_idx(vic_idx),
        .ld_tag(ld_tag), .ld_data(ld_data), .flush(do_flush),
        .lk_vpn(lk_vaddr[31:PG_SHIFT]), .match_vec(match_vec),
        .sel_vpn(sel_vpn), .sel_attr(sel_attr)
    );

    tlb_victim_ctrl #(.NUM_ENT(NUM_ENT)) u_victim (
        .clk(clk), .clr(clr), .lock_we(wr_lock),
        .wr_victim(reg_wdata[LOCK_VICT_LSB +: IDX_W]),
        .wr_base(reg_wdata[LOCK_BASE_LSB +: IDX_W]),
        .adv(do_load), .victim(vic_idx), .base(lock_base)
    );

    logic any_hit, many_hit, ev_miss, ev_multi;
    assign any_hit  = |match_vec;
    assign many_hit = $countones(match_vec) > 1;
    assign ev_miss  = lk_valid && en_q && !any_hit;
    assign ev_multi = lk_valid && en_q && many_hit;

    always_ff @(posedge clk) begin
        if (clr) begin
            en_q      <= 1'b0;
            srst_q    <= 1'b0;
            stg_tag   <= '0;
            stg_data  <= '0;
            irq_st    <= '0;
            irq_en    <= '0;
            lk_ovalid <= 1'b0;
            lk_hit    <= 1'b0;
            lk_miss   <= 1'b0;
            lk_multi  <= 1'b0;
            lk_paddr  <= '0;
            lk_attr   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[1];
                srst_q <= reg_wdata[0];
            end
            if (reg_wr && ra == RA_TAG)  stg_tag  <= reg_wdata;
            if (reg_wr && ra == RA_DATA) stg_data <= reg_wdata;
            if (wr_ie) irq_en <= {reg_wdata[ST_MULTI_BIT], reg_wdata[ST_MISS_BIT]};
            irq_st[0] <= (irq_st[0] & ~(wr_st & reg_wdata[ST_MISS_BIT]))  | ev_miss;
            irq_st[1] <= (irq_st[1] & ~(wr_st & reg_wdata[ST_MULTI_BIT])) | ev_multi;

            lk_ovalid <= lk_valid;
            lk_hit    <= lk_valid && en_q && any_hit;
            lk_miss   <= ev_miss;
            lk_multi  <= ev_multi;
            if (en_q && any_hit) begin
                lk_paddr <= {sel_vpn, lk_vaddr[PG_SHIFT-1:0]};
                lk_attr  <= sel_attr;
            end else begin
                lk_paddr <= lk_vaddr;
                lk_attr  <= '0;
            end
        end
    end

    assign irq      = |(irq_st & irq_en);
    assign rst_done = ~srst_q;

    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_CTRL:  reg_rdata[1] = en_q;
            RA_TAG:   reg_rdata = stg_tag;
            RA_DATA:  reg_rdata = stg_data;
            RA_LOCK: begin
                reg_rdata[LOCK_VICT_LSB +: IDX_W] = vic_idx;
                reg_rdata[LOCK_BASE_LSB +: IDX_W] = lock_base;
            end
            RA_IRQST: begin
                reg_rdata[ST_MISS_BIT]  = irq_st[0];
                reg_rdata[ST_MULTI_BIT] = irq_st[1];
            end
            RA_IRQEN: begin
                reg_rdata[ST_MISS_BIT]  = irq_en[0];
                reg_rdata[ST_MULTI_BIT] = irq_en[1];
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             srst_q,
    input logic             en_q,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             lk_valid,
    input logic [31:0]      lk_vaddr,
    input logic             lk_ovalid,
    input logic [31:0]      lk_paddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_multi,
    input logic [1:0]       irq_st,
    input logic [IDX_W-1:0] vic_idx,
    input logic [IDX_W-1:0] lock_base,
    input logic             rst_done
);
    // R12: no result flags without a result
    a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
        !lk_ovalid |-> !(lk_hit || lk_miss || lk_multi));

    // R7: miss excludes hit and multi, and is recorded in status
    a_r7_miss_exclusive: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> (!lk_hit && !lk_multi && irq_st[0]));

    // R8: multi-match is a hit and is recorded in status
    a_r8_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> (lk_hit && irq_st[1]));

    // R5: replacement pointer stays at or above the lock base
    a_r5_victim_floor: assert property (@(posedge clk) disable iff (rst)
        vic_idx >= lock_base);

    // R9: translation off passes the address through
    a_r9_passthrough: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !en_q && !srst_q) |=>
            (lk_paddr == $past(lk_vaddr) && !lk_hit && !lk_miss && !lk_multi));

    // R10: soft reset drops done for one cycle
    a_r10_done_drops: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[0] && !srst_q) |=> !rst_done);

    a_r10_done_returns: assert property (@(posedge clk) disable iff (rst)
        !rst_done |=> rst_done);
endmodule

bind tlb_xlate tlb_xlate_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .srst_q(srst_q), .en_q(en_q),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ovalid(lk_ovalid),
    .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_multi(lk_multi), .irq_st(irq_st), .vic_idx(vic_idx),
    .lock_base(lock_base), .rst_done(rst_done)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_ovalid, lk_hit, lk_miss, lk_multi, irq, rst_done;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_attr;

    always #2 clk = ~clk;   // 250 MHz

    tlb_xlate #(.NUM_ENT(N)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_ovalid(lk_ovalid), .lk_paddr(lk_paddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi),
        .lk_attr(lk_attr), .irq(irq), .rst_done(rst_done)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    logic        m_vld [N];
    logic        m_pr  [N];
    logic [19:0] m_vt  [N];
    logic [1:0]  m_ps  [N];
    logic [19:0] m_pp  [N];
    logic [3:0]  m_at  [N];
    logic        m_en, m_srst;
    logic [31:0] m_stag, m_sdat, m_st, m_ie;
    logic [4:0]  m_vic, m_base;
    logic        e_ov, e_hit, e_miss, e_multi;
    logic [31:0] e_pa;
    logic [3:0]  e_at;

    function automatic logic [19:0] keep_mask(input logic [1:0] ps);
        int ign;
        ign = (ps == 2'b00) ? 8 : (ps == 2'b01) ? 4 : (ps == 2'b10) ? 0 : 12;
        return 20'hFFFFF << ign;
    endfunction

    always @(posedge clk) begin
        if (rst || m_srst) begin
            for (int i = 0; i < N; i++) begin
                m_vld[i] = 0; m_pr[i] = 0; m_vt[i] = 0; m_ps[i] = 0; m_pp[i] = 0; m_at[i] = 0;
            end
            m_en = 0; m_srst = 0; m_stag = 0; m_sdat = 0; m_st = 0; m_ie = 0;
            m_vic = 0; m_base = 0;
            e_ov = 0; e_hit = 0; e_miss = 0; e_multi = 0; e_pa = 0; e_at = 0;
        end else begin
            int hits;
            int first;
            logic [19:0] km;
            hits = 0; first = -1;
            for (int i = 0; i < N; i++) begin
                if (m_vld[i] && (((lk_vaddr[31:12] ^ m_vt[i]) & keep_mask(m_ps[i])) == 20'h0)) begin
                    hits++;
                    if (first < 0) first = i;
                end
            end
            e_ov    = lk_valid;
            e_hit   = lk_valid && m_en && hits > 0;
            e_miss  = lk_valid && m_en && hits == 0;
            e_multi = lk_valid && m_en && hits > 1;
            if (m_en && hits > 0) begin
                km   = keep_mask(m_ps[first]);
                e_pa = {(m_pp[first] & km) | (lk_vaddr[31:12] & ~km), lk_vaddr[11:0]};
                e_at = m_at[first];
            end else begin
                e_pa = lk_vaddr;
                e_at = 0;
            end
            if (reg_wr && reg_addr == 3'd6) m_st = m_st & ~(reg_wdata & 32'h11);
            if (e_miss)  m_st[0] = 1'b1;
            if (e_multi) m_st[4] = 1'b1;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin m_en = reg_wdata[1]; m_srst = reg_wdata[0]; end
                    3'd1: m_stag = reg_wdata;
                    3'd2: m_sdat = reg_wdata;
                    3'd3: begin
                        m_base = reg_wdata[14:10];
                        m_vic  = (reg_wdata[8:4] < m_base) ? m_base : reg_wdata[8:4];
                    end
                    3'd4: if (reg_wdata[0]) begin
                        m_vt[m_vic]  = m_stag[31:12];
                        m_pr[m_vic]  = m_stag[3];
                        m_vld[m_vic] = m_stag[2];
                        m_ps[m_vic]  = m_stag[1:0];
                        m_pp[m_vic]  = m_sdat[31:12];
                        m_at[m_vic]  = m_sdat[9:6];
                        m_vic = (m_vic == 5'd31) ? m_base : m_vic + 5'd1;
                    end
                    3'd5: if (reg_wdata[0]) begin
                        for (int i = 0; i < N; i++) m_vld[i] = m_vld[i] & m_pr[i];
                    end
                    3'd7: m_ie = reg_wdata & 32'h11;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (reg_addr)
            3'd0: return {30'b0, m_en, 1'b0};
            3'd1: return m_stag;
            3'd2: return m_sdat;
            3'd3: return (32'(m_base) << 10) | (32'(m_vic) << 4);
            3'd6: return m_st;
            3'd7: return m_ie;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string fld, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, fld, act, exp);
        end
    endtask

    // Compare on every clock, half a period after the edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("reg_rdata", reg_rdata, exp_rdata());
            chk("irq", 32'(irq), 32'(|(m_st & m_ie)));
            chk("rst_done", 32'(rst_done), 32'(!m_srst));
            chk("lk_ovalid", 32'(lk_ovalid), 32'(e_ov));
            chk("lk_hit", 32'(lk_hit), 32'(e_hit));
            chk("lk_miss", 32'(lk_miss), 32'(e_miss));
            chk("lk_multi", 32'(lk_multi), 32'(e_multi));
            if (e_ov) begin
                chk("lk_paddr", lk_paddr, e_pa);
                chk("lk_attr", 32'(lk_attr), 32'(e_at));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a;
        @(posedge clk); #1;
    endtask

    task automatic lk(input logic [31:0] va);
        lk_valid = 1'b1; lk_vaddr = va;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic sweep();
        for (int a = 0; a < 8; a++) rd(3'(a));
    endtask

    task automatic load(input logic [31:0] t, input logic [31:0] d);
        wr(3'd1, t); wr(3'd2, d); wr(3'd4, 32'h1);
    endtask

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        cur_req = "R1";  sweep();
        cur_req = "R9";  lk(32'h1234_5678);

        // R2 / R12: 4 KB entry at index 0 with attributes
        cur_req = "R2";
        wr(3'd7, 32'h11);
        load(32'h4000_0006, 32'h8ABC_D340);
        wr(3'd0, 32'h2);
        lk(32'h4000_0ABC);
        cur_req = "R12"; lk(32'h4000_0FFF); rd(3'd3);

        cur_req = "R7";  lk(32'h4000_1ABC); rd(3'd6);

        // R3: the other page sizes
        cur_req = "R3";
        load(32'h1230_0004, 32'hABC0_0000);   // 1 MB
        load(32'h5678_0005, 32'h1111_0240);   // 64 KB
        load(32'h9A00_0007, 32'h7700_00C0);   // 16 MB
        lk(32'h1234_5678); lk(32'h5678_9ABC); lk(32'h9ABC_DEF0); lk(32'h5679_0000);

        // R11: clear and enable handling
        cur_req = "R11";
        rd(3'd6); wr(3'd6, 32'h10); wr(3'd6, 32'h1); wr(3'd7, 32'h10); lk(32'hDEAD_0000);
        wr(3'd6, 32'h1); wr(3'd7, 32'hFFFF_FFFF); rd(3'd7);

        // R8: duplicate 4 KB tag at a higher index
        cur_req = "R8";
        load(32'h4000_0006, 32'h2222_2000);
        lk(32'h4000_0ABC); rd(3'd6);

        // R5: clamp below base, then R4 wrap to base
        cur_req = "R5";
        wr(3'd3, (32'd3 << 10) | (32'd1 << 4)); rd(3'd3);
        wr(3'd3, (32'd6 << 10) | (32'd20 << 4)); rd(3'd3);
        cur_req = "R4";
        for (int i = 0; i < 14; i++) begin
            load(((32'hE0000 + 32'(i)) << 12) | 32'h6, (32'h30000 + 32'(i)) << 12);
            rd(3'd3);
        end
        lk(32'hE000_D010); lk(32'h9ABC_0000);

        // R6: protected entry survives a flush
        cur_req = "R6";
        wr(3'd3, 32'd10 << 4);
        load(32'hCCCC_000E, 32'h5555_5200);
        lk(32'hCCCC_0123); lk(32'h1234_5678);
        wr(3'd5, 32'h1);
        lk(32'hCCCC_0123); lk(32'h1234_5678); lk(32'h4000_0ABC);
        wr(3'd5, 32'h0); lk(32'hCCCC_0FFF);

        cur_req = "R9";
        wr(3'd0, 32'h0); lk(32'hCCCC_0123); lk(32'h0000_0000);

        cur_req = "R10";
        wr(3'd0, 32'h3); rd(3'd0); sweep(); wr(3'd0, 32'h2); lk(32'hCCCC_0123);

        repeat (3) @(posedge clk);
        #1 summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule